// File: doc/BRIEF.md
# Inter-Task Register Forwarding Unit

This block sits in one processing unit of a machine that runs a program as a chain of ordered tasks, each unit holding its own register file with no shared file between units. Live-out register values move only from a task to its direct successor. The unit tracks two register sets for the task it runs. One set holds the registers the task still owes its successor. The other holds the registers it still waits for from its predecessor.

A task begins with a start pulse that carries two masks. The produce mask lists the registers the task will hand on to later code. The consume mask lists the registers it reads that earlier code writes. Retiring instructions write the local file and can ask for their result to be sent on at once, through a per-instruction send flag. An explicit release operation sends the current local value of a named register. The instruction marked as the task's last one causes every produce-mask register not yet sent to be sent from the local file. Values arriving from the predecessor fill the local file and clear the matching wait bit. Arrivals that the task does not produce itself are passed on unchanged. All outgoing values leave through one valid/ready port, one register per transfer, and per-register ready bits tell the local pipeline when a read may proceed.

Top module: `itf_fwd_unit`

## Requirements
- R1: After reset, out_valid is 0 and every bit of reg_ready is 1.
- R2: In the cycle after task_start, reg_ready is 0 for exactly the registers in task_use_mask and 1 for all others, and rd_ok is 0 for a read of such a register.
- R3: A value accepted on the predecessor input sets that register's reg_ready bit from the next cycle, and rd_data then returns the received value.
- R4: A retiring write (ret_valid=1, ret_release=0) stores ret_data into the local file and sets the register's ready bit from the next cycle. When an incoming value for the same register arrives in the same cycle, the local value is kept and the incoming one is discarded without being passed on.
- R5: A retiring write with ret_fwd=1 produces exactly one outgoing transfer carrying ret_dest and ret_data.
- R6: A release (ret_valid=1, ret_release=1) sends the register named by ret_dest with its current local value and leaves the local file unchanged; ret_data is ignored.
- R7: When an instruction with ret_stop=1 retires, every produce-mask register not yet sent is sent with its local file value, and produce-mask registers already sent in this task are not sent again.
- R8: An accepted incoming register absent from the produce mask is passed to the successor with its received value. One present in the produce mask is not passed on.
- R9: While out_valid=1 and out_ready=0, out_valid, out_reg and out_data stay unchanged. At most one register leaves per cycle.
- R10: Registers waiting together to be sent leave in ascending register-number order.
- R11: Retire and incoming events presented in the same cycle as task_start have no effect on the file, the ready bits or the outgoing transfers.
- R12: A register requested for sending several times before it leaves is sent once, carrying its latest local value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_start | input | 1 | Begin a new task; loads the masks |
| task_create_mask | input | NREG | Registers the task produces for later tasks |
| task_use_mask | input | NREG | Registers the task awaits from its predecessor |
| ret_valid | input | 1 | A retiring instruction is presented |
| ret_dest | input | RW | Destination (or released) register number |
| ret_data | input | DW | Result value of the retiring instruction |
| ret_fwd | input | 1 | Send this result to the successor |
| ret_stop | input | 1 | Last instruction of the task |
| ret_release | input | 1 | Release operation: send ret_dest's local value, no write |
| in_valid | input | 1 | Value from the predecessor is present |
| in_reg | input | RW | Register number of the incoming value |
| in_data | input | DW | Incoming value |
| out_valid | output | 1 | Outgoing transfer valid |
| out_ready | input | 1 | Successor accepts the transfer |
| out_reg | output | RW | Register number of the outgoing value |
| out_data | output | DW | Outgoing value |
| reg_ready | output | NREG | Per-register ready-for-local-read bits |
| rd_addr | input | RW | Local read address |
| rd_data | output | DW | Local file value at rd_addr |
| rd_ok | output | 1 | The register at rd_addr is ready |

## Verification
The sending function is tried with a forwarded write alone, with a release of an unforwarded write, with a stop that sweeps up leftover produce-mask registers after one was already forwarded, and with a produce-mask register filled only from the predecessor. Together these separate sends caused by the flag, the release and the stop, and show that nothing is sent twice. Incoming values are applied to registers inside and outside the produce mask, to tell passing on apart from absorbing. A stalled successor with a repeated request tests holding and merging. Same-cycle collisions, local write against incoming value and task start against retire, pin down the priority rules.

// File: rtl/itf_pkg.sv
package itf_pkg;

    localparam int unsigned ITF_NREG = 32;
    localparam int unsigned ITF_DW   = 32;

    typedef enum logic [1:0] {
        RET_IDLE    = 2'd0,
        RET_WRITE   = 2'd1,
        RET_RELEASE = 2'd2
    } ret_op_e;

    typedef struct packed {
        logic                    valid;
        logic [ITF_NREG-1:0]     reg_oh;
    } itf_hit_t;

endpackage

// File: rtl/itf_regfile.sv
module itf_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_loc,
    input  logic [RW-1:0] wa_loc,
    input  logic [DW-1:0] wd_loc,
    input  logic          we_in,
    input  logic [RW-1:0] wa_in,
    input  logic [DW-1:0] wd_in,
    input  logic [RW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [RW-1:0] ra1,
    output logic [DW-1:0] rd1
);
    logic [NREG-1:0][DW-1:0] mem;
    logic [NREG-1:0]         sel_loc;
    logic [NREG-1:0]         sel_in;

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel_loc[g] = we_loc && (wa_loc == RW'(g));
        assign sel_in[g]  = we_in  && (wa_in  == RW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (sel_loc[i])
                    mem[i] <= wd_loc;
                else if (sel_in[i])
                    mem[i] <= wd_in;
            end
        end
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
endmodule

// File: rtl/itf_track.sv
module itf_track
    import itf_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NREG-1:0] cre_in,
    input  logic [NREG-1:0] use_in,
    input  ret_op_e         op,
    input  logic [RW-1:0]   op_reg,
    input  logic            op_fwd,
    input  logic            op_stop,
    input  logic            in_v,
    input  logic [RW-1:0]   in_reg,
    input  logic            take,
    input  logic [RW-1:0]   take_reg,
    output logic            in_acc,
    output logic [NREG-1:0] wait_q,
    output logic [NREG-1:0] pend_q
);
    logic [NREG-1:0] cre_mask_q;
    logic [NREG-1:0] cre_left_q;
    logic [NREG-1:0] written_q;

    function automatic logic [NREG-1:0] onehot(input logic [RW-1:0] a);
        return {{(NREG-1){1'b0}}, 1'b1} << a;
    endfunction

    itf_hit_t loc_hit, in_hit, send_hit, take_hit;
    logic [NREG-1:0] cre_left_n, pend_n, wait_n, written_n;

    always_comb begin
        loc_hit.valid   = (op == RET_WRITE);
        loc_hit.reg_oh  = loc_hit.valid ? onehot(op_reg) : '0;
        send_hit.valid  = (op == RET_RELEASE) || ((op == RET_WRITE) && op_fwd);
        send_hit.reg_oh = send_hit.valid ? onehot(op_reg) : '0;
        take_hit.valid  = take;
        take_hit.reg_oh = take ? onehot(take_reg) : '0;

        in_acc = in_v && !written_q[in_reg]
                 && !(loc_hit.valid && (op_reg == in_reg));
        in_hit.valid  = in_v;
        in_hit.reg_oh = in_v ? onehot(in_reg) : '0;

        wait_n     = wait_q & ~loc_hit.reg_oh & ~in_hit.reg_oh;
        written_n  = written_q | loc_hit.reg_oh;
        cre_left_n = cre_left_q & ~take_hit.reg_oh;

        pend_n = (pend_q & ~take_hit.reg_oh) | send_hit.reg_oh;
        if (in_acc && !cre_mask_q[in_reg])
            pend_n = pend_n | in_hit.reg_oh;
        if ((op != RET_IDLE) && op_stop)
            pend_n = pend_n | cre_left_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q     <= '0;
            pend_q     <= '0;
            cre_mask_q <= '0;
            cre_left_q <= '0;
            written_q  <= '0;
        end else if (start) begin
            wait_q     <= use_in;
            pend_q     <= '0;
            cre_mask_q <= cre_in;
            cre_left_q <= cre_in;
            written_q  <= '0;
        end else begin
            wait_q     <= wait_n;
            pend_q     <= pend_n;
            cre_left_q <= cre_left_n;
            written_q  <= written_n;
        end
    end
endmodule

// File: rtl/itf_pick.sv
module itf_pick #(
    parameter int NREG = 32,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0] vec,
    output logic            any,
    output logic [RW-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec[i])
                idx = RW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/itf_fwd_unit.sv
module itf_fwd_unit
    import itf_pkg::*;
#(
    parameter int NREG = ITF_NREG,
    parameter int DW   = ITF_DW,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            task_start,
    input  logic [NREG-1:0] task_create_mask,
    input  logic [NREG-1:0] task_use_mask,
    input  logic            ret_valid,
    input  logic [RW-1:0]   ret_dest,
    input  logic [DW-1:0]   ret_data,
    input  logic            ret_fwd,
    input  logic            ret_stop,
    input  logic            ret_release,
    input  logic            in_valid,
    input  logic [RW-1:0]   in_reg,
    input  logic [DW-1:0]   in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [RW-1:0]   out_reg,
    output logic [DW-1:0]   out_data,
    output logic [NREG-1:0] reg_ready,
    input  logic [RW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            rd_ok
);
    ret_op_e         op;
    logic            loc_we;
    logic            in_v;
    logic            in_acc;
    logic [NREG-1:0] wait_q;
    logic [NREG-1:0] pend_q;
    logic            pick_any;
    logic [RW-1:0]   pick_idx;
    logic [DW-1:0]   pick_val;
    logic            take;

    logic            slot_v;
    logic [RW-1:0]   slot_reg;
    logic [DW-1:0]   slot_dat;

    always_comb begin
        if (!ret_valid || task_start)
            op = RET_IDLE;
        else if (ret_release)
            op = RET_RELEASE;
        else
            op = RET_WRITE;
    end

    assign loc_we = (op == RET_WRITE);
    assign in_v   = in_valid && !task_start;

    itf_track #(.NREG(NREG)) u_track (
        .clk      (clk),
        .rst      (rst),
        .start    (task_start),
        .cre_in   (task_create_mask),
        .use_in   (task_use_mask),
        .op       (op),
        .op_reg   (ret_dest),
        .op_fwd   (ret_fwd),
        .op_stop  (ret_stop),
        .in_v     (in_v),
        .in_reg   (in_reg),
        .take     (take),
        .take_reg (pick_idx),
        .in_acc   (in_acc),
        .wait_q   (wait_q),
        .pend_q   (pend_q)
    );

    itf_regfile #(.NREG(NREG), .DW(DW)) u_file (
        .clk    (clk),
        .rst    (rst),
        .we_loc (loc_we),
        .wa_loc (ret_dest),
        .wd_loc (ret_data),
        .we_in  (in_acc),
        .wa_in  (in_reg),
        .wd_in  (in_data),
        .ra0    (rd_addr),
        .rd0    (rd_data),
        .ra1    (pick_idx),
        .rd1    (pick_val)
    );

    itf_pick #(.NREG(NREG)) u_pick (
        .vec (pend_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign take = pick_any && (!slot_v || out_ready) && !task_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v   <= 1'b0;
            slot_reg <= '0;
            slot_dat <= '0;
        end else if (take) begin
            slot_v   <= 1'b1;
            slot_reg <= pick_idx;
            if (loc_we && (ret_dest == pick_idx))
                slot_dat <= ret_data;
            else if (in_acc && (in_reg == pick_idx))
                slot_dat <= in_data;
            else
                slot_dat <= pick_val;
        end else if (out_ready) begin
            slot_v <= 1'b0;
        end
    end

    assign out_valid = slot_v;
    assign out_reg   = slot_reg;
    assign out_data  = slot_dat;
    assign reg_ready = ~wait_q;
    assign rd_ok     = ~wait_q[rd_addr];
endmodule

// File: rtl/itf_fwd_unit_chk.sv
module itf_fwd_unit_chk #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            task_start,
    input logic [NREG-1:0] task_use_mask,
    input logic            ret_valid,
    input logic [RW-1:0]   ret_dest,
    input logic            ret_release,
    input logic            in_valid,
    input logic [RW-1:0]   in_reg,
    input logic            out_valid,
    input logic            out_ready,
    input logic [RW-1:0]   out_reg,
    input logic [DW-1:0]   out_data,
    input logic [NREG-1:0] reg_ready
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_start_wait_r2: assert property (@(posedge clk) disable iff (rst)
        task_start |=> ((reg_ready & $past(task_use_mask)) == '0));

    p_recv_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !task_start) |=> reg_ready[$past(in_reg)]);

    p_local_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_release && !task_start) |=> reg_ready[$past(ret_dest)]);

    p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_reg) && $stable(out_data)));
endmodule

bind itf_fwd_unit itf_fwd_unit_chk #(.NREG(NREG), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .task_start    (task_start),
    .task_use_mask (task_use_mask),
    .ret_valid     (ret_valid),
    .ret_dest      (ret_dest),
    .ret_release   (ret_release),
    .in_valid      (in_valid),
    .in_reg        (in_reg),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_reg       (out_reg),
    .out_data      (out_data),
    .reg_ready     (reg_ready)
);

// File: tb/itf_fwd_unit_bench.sv
module itf_fwd_unit_bench;
    import itf_pkg::*;

    localparam int NREG = ITF_NREG;
    localparam int DW   = ITF_DW;
    localparam int RW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst;
    logic            task_start;
    logic [NREG-1:0] task_create_mask, task_use_mask;
    logic            ret_valid, ret_fwd, ret_stop, ret_release;
    logic [RW-1:0]   ret_dest;
    logic [DW-1:0]   ret_data;
    logic            in_valid;
    logic [RW-1:0]   in_reg;
    logic [DW-1:0]   in_data;
    logic            out_valid, out_ready;
    logic [RW-1:0]   out_reg;
    logic [DW-1:0]   out_data;
    logic [NREG-1:0] reg_ready;
    logic [RW-1:0]   rd_addr;
    logic [DW-1:0]   rd_data;
    logic            rd_ok;

    int n_chk = 0;
    int n_bad = 0;
    logic [RW-1:0] q_reg[$];
    logic [DW-1:0] q_dat[$];

    always #2 clk = ~clk;

    itf_fwd_unit u_itf_fwd_unit (
        .clk(clk), .rst(rst), .task_start(task_start),
        .task_create_mask(task_create_mask), .task_use_mask(task_use_mask),
        .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_data(ret_data),
        .ret_fwd(ret_fwd), .ret_stop(ret_stop), .ret_release(ret_release),
        .in_valid(in_valid), .in_reg(in_reg), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_reg(out_reg),
        .out_data(out_data), .reg_ready(reg_ready), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ok(rd_ok)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            q_reg.push_back(out_reg);
            q_dat.push_back(out_data);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        task_start = 0; task_create_mask = '0; task_use_mask = '0;
        ret_valid = 0; ret_dest = '0; ret_data = '0;
        ret_fwd = 0; ret_stop = 0; ret_release = 0;
        in_valid = 0; in_reg = '0; in_data = '0;
    endtask

    task automatic do_start(input logic [NREG-1:0] cm, input logic [NREG-1:0] um);
        task_start = 1; task_create_mask = cm; task_use_mask = um;
        tick();
        idle_in();
    endtask

    task automatic do_ret(input int d, input logic [DW-1:0] v, input bit f, input bit s, input bit r);
        ret_valid = 1; ret_dest = RW'(d); ret_data = v;
        ret_fwd = f; ret_stop = s; ret_release = r;
        tick();
        idle_in();
    endtask

    task automatic do_in(input int r, input logic [DW-1:0] v);
        in_valid = 1; in_reg = RW'(r); in_data = v;
        tick();
        idle_in();
    endtask

    task automatic drain_and_clear();
        repeat (6) tick();
        q_reg.delete();
        q_dat.delete();
    endtask

    task automatic chk_msg(input int i, input int r, input logic [DW-1:0] v, input string req);
        if (q_reg.size() > i) begin
            chk(q_reg[i] == RW'(r), req, 64'(q_reg[i]), 64'(r));
            chk(q_dat[i] == v, req, 64'(q_dat[i]), 64'(v));
        end else begin
            chk(1'b0, req, 64'(q_reg.size()), 64'(i + 1));
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
        chk(reg_ready == '1, "R1 reg_ready", 64'(reg_ready), 64'({NREG{1'b1}}));
    endtask

    task automatic t_use_and_pass();
        logic [NREG-1:0] um;
        um = (NREG'(1) << 3) | (NREG'(1) << 5);
        do_start('0, um);
        chk(reg_ready == ~um, "R2 ready bits", 64'(reg_ready), 64'(~um));
        rd_addr = 3; #0;
        chk(rd_ok == 1'b0, "R2 rd_ok", 64'(rd_ok), 0);
        do_in(3, 32'hAAAA);
        chk(reg_ready[3] == 1'b1, "R3 ready set", 64'(reg_ready[3]), 1);
        chk(reg_ready[5] == 1'b0, "R3 other waits", 64'(reg_ready[5]), 0);
        chk(rd_data == 32'hAAAA, "R3 value", 64'(rd_data), 64'h AAAA);
        repeat (5) tick();
        chk(q_reg.size() == 1, "R8 pass count", 64'(q_reg.size()), 1);
        chk_msg(0, 3, 32'hAAAA, "R8 pass msg");
        drain_and_clear();
    endtask

    task automatic t_fwd();
        do_start(NREG'(1) << 7, '0);
        do_ret(7, 32'h1234, 1, 0, 0);
        do_ret(1, 32'h55, 0, 1, 0);
        repeat (5) tick();
        chk(q_reg.size() == 1, "R5 single send, R7 no resend", 64'(q_reg.size()), 1);
        chk_msg(0, 7, 32'h1234, "R5 fwd msg");
        drain_and_clear();
    endtask

    task automatic t_stop();
        logic [NREG-1:0] cm;
        cm = (NREG'(1) << 2) | (NREG'(1) << 9) | (NREG'(1) << 20);
        do_start(cm, '0);
        do_ret(9,  32'h99, 0, 0, 0);
        do_ret(2,  32'h22, 0, 0, 0);
        do_ret(20, 32'h2020, 1, 0, 0);
        do_ret(0,  32'h0, 0, 1, 0);
        repeat (6) tick();
        chk(q_reg.size() == 3, "R7 count", 64'(q_reg.size()), 3);
        chk_msg(0, 20, 32'h2020, "R7 fwd first");
        chk_msg(1, 2, 32'h22, "R10 ascending");
        chk_msg(2, 9, 32'h99, "R10 ascending");
        drain_and_clear();
    endtask

    task automatic t_release();
        do_start('0, '0);
        do_ret(4, 32'h44, 0, 0, 0);
        repeat (3) tick();
        chk(q_reg.size() == 0, "R6 plain write silent", 64'(q_reg.size()), 0);
        do_ret(4, 32'hDEAD, 0, 0, 1);
        repeat (5) tick();
        chk_msg(0, 4, 32'h44, "R6 release msg");
        rd_addr = 4; #0;
        chk(rd_data == 32'h44, "R6 file unchanged", 64'(rd_data), 64'h44);
        drain_and_clear();
    endtask

    task automatic t_recv_create();
        do_start(NREG'(1) << 6, NREG'(1) << 6);
        do_in(6, 32'h66);
        repeat (4) tick();
        chk(q_reg.size() == 0, "R8 absorbed", 64'(q_reg.size()), 0);
        do_ret(1, 32'h11, 0, 1, 0);
        repeat (5) tick();
        chk(q_reg.size() == 1, "R7 stop sweep count", 64'(q_reg.size()), 1);
        chk_msg(0, 6, 32'h66, "R7 stop sweep value");
        drain_and_clear();
    endtask

    task automatic t_hold();
        do_start('0, '0);
        out_ready = 0;
        do_ret(10, 32'hA, 1, 0, 0);
        do_ret(11, 32'hB, 1, 0, 0);
        do_ret(11, 32'hC, 1, 0, 0);
        tick();
        chk(out_valid && out_reg == RW'(10) && out_data == 32'hA, "R9 held",
            64'({out_valid, out_reg, out_data}), 64'({1'b1, RW'(10), 32'hA}));
        repeat (2) tick();
        chk(out_valid && out_reg == RW'(10) && out_data == 32'hA, "R9 still held",
            64'({out_valid, out_reg, out_data}), 64'({1'b1, RW'(10), 32'hA}));
        out_ready = 1;
        repeat (5) tick();
        chk(q_reg.size() == 2, "R12 merged count", 64'(q_reg.size()), 2);
        chk_msg(0, 10, 32'hA, "R9 first");
        chk_msg(1, 11, 32'hC, "R12 latest value");
        drain_and_clear();
    endtask

    task automatic t_start_ignore();
        task_start = 1; task_create_mask = '0; task_use_mask = NREG'(1) << 8;
        ret_valid = 1; ret_dest = 8; ret_data = 32'h88; ret_fwd = 1;
        in_valid = 1; in_reg = 8; in_data = 32'h77;
        tick();
        idle_in();
        chk(reg_ready[8] == 1'b0, "R11 still waiting", 64'(reg_ready[8]), 0);
        rd_addr = 8; #0;
        chk(rd_data == '0, "R11 file untouched", 64'(rd_data), 0);
        repeat (5) tick();
        chk(q_reg.size() == 0, "R11 nothing sent", 64'(q_reg.size()), 0);
        drain_and_clear();
    endtask

    task automatic t_local_wins();
        do_start('0, NREG'(1) << 13);
        ret_valid = 1; ret_dest = 13; ret_data = 32'h1313;
        in_valid = 1; in_reg = 13; in_data = 32'h9999;
        tick();
        idle_in();
        rd_addr = 13; #0;
        chk(rd_data == 32'h1313, "R4 local wins", 64'(rd_data), 64'h1313);
        chk(rd_ok == 1'b1, "R4 ready", 64'(rd_ok), 1);
        repeat (5) tick();
        chk(q_reg.size() == 0, "R4 incoming dropped", 64'(q_reg.size()), 0);
        drain_and_clear();
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_in();
        rst = 1; out_ready = 0; rd_addr = '0;
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        out_ready = 1;
        t_use_and_pass();
        t_fwd();
        t_stop();
        t_release();
        t_recv_create();
        t_hold();
        t_start_ignore();
        t_local_wins();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule